// File: doc/BRIEF.md
# PHY Presence and Link Polling Scanner

This block runs beside a management-bus controller. While the controller is enabled, it reads the basic status register of each PHY address in turn, wrapping from the last address back to zero. For every address it keeps two bits. One is an alive bit, which records whether that PHY acknowledged its most recent poll. The other is a link bit, taken from the returned status word. When a polled link state differs from the stored one, a per-PHY change flag is raised. Software clears a change flag by writing a 1 to it, and a per-PHY enable mask selects which flags reach the interrupt output.

The scanner shares one frame engine with software-initiated register accesses. The engine is reached through a request/done port, and a request is held steady until the engine reports that the frame has finished. A frame that has started is never aborted. A software access that is waiting takes the next free frame slot, so it waits at most one poll frame. After the software frame, polling picks up at the address that follows the last one polled. When the enable is cleared, the frame in flight finishes, no new frame starts, and the scanner reports idle.

Top module: `mdio_scan_top`

## Requirements
- R1: After reset, alive, link, raw change and masked change are all zero, the change mask is zero, fe_req is low, and idle is high while enable is low.
- R2: Each poll frame is a read (fe_wr=0) of register number 1 (fe_reg=1). Polled addresses run 0,1,2,…,31 and then wrap to 0. A software frame is not counted in this order. With no software traffic, every address is polled once in 32 consecutive frames.
- R3: One cycle after a poll frame completes (fe_done high), alive bit [fe_phy] equals fe_ack of that frame. An address that stops acknowledging is cleared on its next poll.
- R4: One cycle after a poll frame completes, link bit [fe_phy] equals fe_ack AND bit 2 of fe_rdata. A PHY that does not acknowledge reads as link down.
- R5: A raw change bit is set when a poll yields a link value different from the stored link bit. A write with chg_clr_wr clears every raw bit whose chg_clr_bits position is 1. A set in the same cycle wins over the clear.
- R6: chg_masked equals chg_raw AND the mask register. The mask register is loaded from chg_mask_bits when chg_mask_wr is high.
- R7: A software request that is pending when a frame ends is served by the very next frame, ahead of the next poll.
- R8: A software frame drives fe_wr, fe_phy, fe_reg and fe_wdata from usr_wr, usr_phy, usr_reg and usr_wdata. One cycle after its fe_done, usr_done pulses for one cycle with usr_ack=fe_ack and usr_rdata=fe_rdata. The request is not served again while usr_done is high.
- R9: When enable is cleared during a frame, that frame completes. No further frame starts, and idle goes high once no frame is in flight.
- R10: Once fe_req is raised, it stays high with fe_phy, fe_reg and fe_wr stable until the cycle in which fe_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; frames start only while high |
| usr_req | input | 1 | Software access request, held until usr_done |
| usr_wr | input | 1 | Software access is a write |
| usr_phy | input | 5 | Software access PHY address |
| usr_reg | input | 5 | Software access register number |
| usr_wdata | input | 16 | Software write data |
| usr_done | output | 1 | One-cycle pulse when the software frame ends |
| usr_ack | output | 1 | PHY acknowledged the software frame |
| usr_rdata | output | 16 | Data returned by the software frame |
| fe_req | output | 1 | Frame request to the engine |
| fe_wr | output | 1 | Frame is a write |
| fe_phy | output | 5 | Frame PHY address |
| fe_reg | output | 5 | Frame register number |
| fe_wdata | output | 16 | Frame write data |
| fe_done | input | 1 | Engine reports that the frame has finished |
| fe_ack | input | 1 | PHY acknowledged the frame |
| fe_rdata | input | 16 | Frame read data |
| chg_clr_wr | input | 1 | Write strobe for clearing raw change bits |
| chg_clr_bits | input | 32 | Raw change bits to clear (1 = clear) |
| chg_mask_wr | input | 1 | Write strobe for the change mask |
| chg_mask_bits | input | 32 | New change mask value |
| idle | output | 1 | No frame in flight and enable low |
| alive | output | 32 | Per-PHY acknowledged-last-poll bits |
| link | output | 32 | Per-PHY polled link state |
| chg_raw | output | 32 | Per-PHY raw link-change flags |
| chg_masked | output | 32 | Raw change flags ANDed with the mask |

## Verification
The alive, link and raw change bits are registered on the edge where fe_done is high, so they can be read one cycle later. The bench reads them only after a whole run of poll frames has finished, one falling edge after the last completion. usr_done, usr_ack and usr_rdata are due one cycle after the software frame's fe_done. The bench samples them on the falling edge on which usr_done is high. The next frame's fe_req rises two edges after fe_done. The bench's PHY responder picks every frame up on a falling edge. It checks the poll order and the software frame's position against counts of its own, so a late or early frame shows up as a wrong address or a wrong frame index.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_POLL = 2'd1,
    SQ_SOFT = 2'd2
  } seq_state_t;

  // next poll address with wrap at the address count
  function automatic int unsigned wrap_next(input int unsigned a, input int unsigned n);
    return (a + 1 >= n) ? 0 : a + 1;
  endfunction

  // link state carried by a completed poll frame
  function automatic logic link_from(input logic ack, input logic [31:0] rd,
                                     input int unsigned bitpos);
    return ack & rd[bitpos];
  endfunction

endpackage

// File: rtl/mdio_scan_seq.sv
module mdio_scan_seq
  import mdio_scan_pkg::*;
#(
  parameter int NPHY     = 32,
  parameter int DW       = 16,
  parameter int RW       = 5,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2,
  localparam int AW      = $clog2(NPHY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          usr_req,
  input  logic          usr_wr,
  input  logic [AW-1:0] usr_phy,
  input  logic [RW-1:0] usr_reg,
  input  logic [DW-1:0] usr_wdata,
  output logic          usr_done,
  output logic          usr_ack,
  output logic [DW-1:0] usr_rdata,
  output logic          fe_req,
  output logic          fe_wr,
  output logic [AW-1:0] fe_phy,
  output logic [RW-1:0] fe_reg,
  output logic [DW-1:0] fe_wdata,
  input  logic          fe_done,
  input  logic          fe_ack,
  input  logic [DW-1:0] fe_rdata,
  output logic          idle,
  output logic          poll_upd,
  output logic [AW-1:0] poll_phy,
  output logic          poll_ack,
  output logic          poll_link
);

  seq_state_t    state;
  logic [AW-1:0] ptr;
  logic          soft_go;
  logic          poll_go;

  // named events for the checks below
  assign soft_go   = (state == SQ_IDLE) && enable && usr_req && !usr_done;
  assign poll_go   = (state == SQ_IDLE) && enable && !soft_go;
  assign poll_upd  = (state == SQ_POLL) && fe_done;
  assign poll_phy  = fe_phy;
  assign poll_ack  = fe_ack;
  assign poll_link = link_from(fe_ack, 32'(fe_rdata), LINK_BIT);

  assign fe_req = (state != SQ_IDLE);
  assign idle   = (state == SQ_IDLE) && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      ptr       <= '0;
      fe_wr     <= 1'b0;
      fe_phy    <= '0;
      fe_reg    <= '0;
      fe_wdata  <= '0;
      usr_done  <= 1'b0;
      usr_ack   <= 1'b0;
      usr_rdata <= '0;
    end else begin
      usr_done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (soft_go) begin
            state    <= SQ_SOFT;
            fe_wr    <= usr_wr;
            fe_phy   <= usr_phy;
            fe_reg   <= usr_reg;
            fe_wdata <= usr_wdata;
          end else if (poll_go) begin
            state    <= SQ_POLL;
            fe_wr    <= 1'b0;
            fe_phy   <= ptr;
            fe_reg   <= RW'(STAT_REG);
            fe_wdata <= '0;
          end
        end
        SQ_POLL: begin
          if (fe_done) begin
            state <= SQ_IDLE;
            ptr   <= AW'(wrap_next(int'(ptr), NPHY));
          end
        end
        SQ_SOFT: begin
          if (fe_done) begin
            state     <= SQ_IDLE;
            usr_done  <= 1'b1;
            usr_ack   <= fe_ack;
            usr_rdata <= fe_rdata;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R10: a frame is never dropped or altered before the engine finishes it
  a_r10_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req && !fe_done) |=> (fe_req && $stable(fe_phy) && $stable(fe_reg) && $stable(fe_wr)));

  // R9: idle never coexists with a frame in flight
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !fe_req);

  // R7: a pending software access owns the next frame
  a_r7_soft_first: assert property (@(posedge clk) disable iff (!rst_n)
    soft_go |=> (fe_req && fe_phy == $past(usr_phy) && fe_reg == $past(usr_reg)
                 && fe_wr == $past(usr_wr)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> !usr_done);

  // R2: poll frames are reads of the status register
  a_r2_poll_shape: assert property (@(posedge clk) disable iff (!rst_n)
    poll_go |=> (fe_req && !fe_wr && fe_reg == RW'(STAT_REG)));

endmodule

// File: rtl/mdio_scan_status.sv
module mdio_scan_status
#(
  parameter int NPHY = 32,
  localparam int AW  = $clog2(NPHY)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            poll_upd,
  input  logic [AW-1:0]   poll_phy,
  input  logic            poll_ack,
  input  logic            poll_link,
  output logic [NPHY-1:0] alive,
  output logic [NPHY-1:0] link,
  output logic [NPHY-1:0] chg_evt
);

  for (genvar i = 0; i < NPHY; i++) begin : g_phy
    logic hit;
    assign hit        = poll_upd && (poll_phy == AW'(i));
    assign chg_evt[i] = hit && (poll_link != link[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alive[i] <= 1'b0;
        link[i]  <= 1'b0;
      end else if (hit) begin
        alive[i] <= poll_ack;
        link[i]  <= poll_link;
      end
    end
  end

  // R3: alive bit tracks the acknowledge of the latest poll
  a_r3_alive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    poll_upd |=> (alive[$past(poll_phy)] == $past(poll_ack)));

  // R4: a silent PHY reads as link down
  a_r4_silent_down: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_upd && !poll_ack) |=> !link[$past(poll_phy)]);

  // R5: at most one change event per completed poll
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg_evt));

endmodule

// File: rtl/mdio_scan_irq.sv
module mdio_scan_irq
#(
  parameter int NPHY = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPHY-1:0] chg_evt,
  input  logic            clr_wr,
  input  logic [NPHY-1:0] clr_bits,
  input  logic            mask_wr,
  input  logic [NPHY-1:0] mask_bits,
  output logic [NPHY-1:0] chg_raw,
  output logic [NPHY-1:0] chg_masked
);

  logic [NPHY-1:0] mask_q;
  logic [NPHY-1:0] clr_eff;

  assign clr_eff    = clr_wr ? clr_bits : '0;
  assign chg_masked = chg_raw & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_raw <= '0;
      mask_q  <= '0;
    end else begin
      chg_raw <= (chg_raw & ~clr_eff) | chg_evt;
      if (mask_wr) mask_q <= mask_bits;
    end
  end

  // R5: a new change event survives a simultaneous clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg_evt) |=> ((chg_raw & $past(chg_evt)) == $past(chg_evt)));

  // R5: cleared bits without a fresh event read zero afterwards
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(|chg_evt)) |=> ((chg_raw & $past(clr_bits)) == '0));

  // R6: a new mask applies from the next cycle
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !(|chg_evt) && !clr_wr) |=> (chg_masked == (chg_raw & $past(mask_bits))));

endmodule

// File: rtl/mdio_scan_top.sv
module mdio_scan_top
#(
  parameter int NPHY     = 32,
  parameter int DW       = 16,
  parameter int RW       = 5,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2,
  localparam int AW      = $clog2(NPHY)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            usr_req,
  input  logic            usr_wr,
  input  logic [AW-1:0]   usr_phy,
  input  logic [RW-1:0]   usr_reg,
  input  logic [DW-1:0]   usr_wdata,
  output logic            usr_done,
  output logic            usr_ack,
  output logic [DW-1:0]   usr_rdata,
  output logic            fe_req,
  output logic            fe_wr,
  output logic [AW-1:0]   fe_phy,
  output logic [RW-1:0]   fe_reg,
  output logic [DW-1:0]   fe_wdata,
  input  logic            fe_done,
  input  logic            fe_ack,
  input  logic [DW-1:0]   fe_rdata,
  input  logic            chg_clr_wr,
  input  logic [NPHY-1:0] chg_clr_bits,
  input  logic            chg_mask_wr,
  input  logic [NPHY-1:0] chg_mask_bits,
  output logic            idle,
  output logic [NPHY-1:0] alive,
  output logic [NPHY-1:0] link,
  output logic [NPHY-1:0] chg_raw,
  output logic [NPHY-1:0] chg_masked
);

  logic            poll_upd;
  logic [AW-1:0]   poll_phy;
  logic            poll_ack;
  logic            poll_link;
  logic [NPHY-1:0] chg_evt;

  mdio_scan_seq #(
    .NPHY(NPHY), .DW(DW), .RW(RW), .STAT_REG(STAT_REG), .LINK_BIT(LINK_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .usr_req(usr_req), .usr_wr(usr_wr), .usr_phy(usr_phy), .usr_reg(usr_reg),
    .usr_wdata(usr_wdata), .usr_done(usr_done), .usr_ack(usr_ack), .usr_rdata(usr_rdata),
    .fe_req(fe_req), .fe_wr(fe_wr), .fe_phy(fe_phy), .fe_reg(fe_reg), .fe_wdata(fe_wdata),
    .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
    .idle(idle), .poll_upd(poll_upd), .poll_phy(poll_phy),
    .poll_ack(poll_ack), .poll_link(poll_link)
  );

  mdio_scan_status #(.NPHY(NPHY)) u_status (
    .clk(clk), .rst_n(rst_n), .poll_upd(poll_upd), .poll_phy(poll_phy),
    .poll_ack(poll_ack), .poll_link(poll_link),
    .alive(alive), .link(link), .chg_evt(chg_evt)
  );

  mdio_scan_irq #(.NPHY(NPHY)) u_irq (
    .clk(clk), .rst_n(rst_n), .chg_evt(chg_evt),
    .clr_wr(chg_clr_wr), .clr_bits(chg_clr_bits),
    .mask_wr(chg_mask_wr), .mask_bits(chg_mask_bits),
    .chg_raw(chg_raw), .chg_masked(chg_masked)
  );

endmodule

// File: tb/mdio_scan_top_bench.sv
module mdio_scan_top_bench;

  localparam int LAT     = 3;
  localparam int SOFTREG = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        usr_req, usr_wr;
  logic [4:0]  usr_phy, usr_reg;
  logic [15:0] usr_wdata;
  logic        usr_done, usr_ack;
  logic [15:0] usr_rdata;
  logic        fe_req, fe_wr;
  logic [4:0]  fe_phy, fe_reg;
  logic [15:0] fe_wdata;
  logic        fe_done, fe_ack;
  logic [15:0] fe_rdata;
  logic        chg_clr_wr, chg_mask_wr;
  logic [31:0] chg_clr_bits, chg_mask_bits;
  logic        idle;
  logic [31:0] alive, link, chg_raw, chg_masked;

  always #10 clk = ~clk;

  mdio_scan_top u_mdio_scan_top (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .usr_req(usr_req), .usr_wr(usr_wr), .usr_phy(usr_phy), .usr_reg(usr_reg),
    .usr_wdata(usr_wdata), .usr_done(usr_done), .usr_ack(usr_ack), .usr_rdata(usr_rdata),
    .fe_req(fe_req), .fe_wr(fe_wr), .fe_phy(fe_phy), .fe_reg(fe_reg), .fe_wdata(fe_wdata),
    .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
    .chg_clr_wr(chg_clr_wr), .chg_clr_bits(chg_clr_bits),
    .chg_mask_wr(chg_mask_wr), .chg_mask_bits(chg_mask_bits),
    .idle(idle), .alive(alive), .link(link), .chg_raw(chg_raw), .chg_masked(chg_masked)
  );

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  logic [31:0] phy_alive = '0, phy_link = '0;
  int    exp_ptr = 0, frames_started = 0, scan_done = 0, soft_idx = -1;
  bit    resp_busy = 0, soft_expect = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // PHY side of the frame engine
  initial begin
    fe_done = 0; fe_ack = 0; fe_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && fe_req) begin
        logic [4:0] cp; logic [4:0] cr; logic cw; logic [15:0] cwd; bit is_soft;
        cp = fe_phy; cr = fe_reg; cw = fe_wr; cwd = fe_wdata;
        frames_started++;
        resp_busy = 1;
        is_soft = soft_expect && cr == usr_reg && cp == usr_phy;
        if (is_soft) begin
          soft_idx = frames_started;
          soft_expect = 0;
          chk(cw == usr_wr, "R8 soft frame direction", 32'(cw), 32'(usr_wr));
          if (cw) chk(cwd == usr_wdata, "R8 soft write data", 32'(cwd), 32'(usr_wdata));
        end else begin
          chk(cp == 5'(exp_ptr) && cr == 5'd1 && !cw, "R2 poll address/register",
              {cw, 11'd0, cr, 10'd0, cp}, {12'd0, 5'd1, 10'd0, 5'(exp_ptr)});
          exp_ptr = (exp_ptr + 1) % 32;
        end
        repeat (LAT) @(negedge clk);
        chk(fe_req && fe_phy == cp, "R10 request held", {31'd0, fe_req}, 32'd1);
        if (is_soft) begin
          fe_ack = 1'b1;
          fe_rdata = 16'hC0DE ^ {11'd0, cp};
        end else begin
          fe_ack = phy_alive[cp];
          fe_rdata = ({11'h2A5, cp} & 16'hFFFB) | {13'd0, phy_link[cp], 2'b00};
        end
        fe_done = 1'b1;
        @(negedge clk);
        fe_done = 1'b0;
        if (!is_soft) scan_done++;
        resp_busy = 0;
      end
    end
  end

  task automatic wait_scans(input int n);
    int target;
    target = scan_done + n;
    while (scan_done < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_mid_frame();
    @(negedge clk);
    while (!(resp_busy && !fe_done)) @(negedge clk);
  endtask

  task automatic soft_op(input bit wr, input logic [4:0] phy, input logic [15:0] wd);
    int n;
    wait_mid_frame();
    usr_wr = wr; usr_phy = phy; usr_reg = 5'(SOFTREG); usr_wdata = wd;
    soft_expect = 1; usr_req = 1;
    n = frames_started;
    while (!usr_done) @(negedge clk);
    chk(soft_idx == n + 1, "R7 soft frame follows current frame", 32'(soft_idx), 32'(n + 1));
    chk(usr_ack == 1'b1, "R8 usr_ack", 32'(usr_ack), 32'd1);
    if (!wr) chk(usr_rdata == (16'hC0DE ^ {11'd0, phy}), "R8 usr_rdata",
                 32'(usr_rdata), 32'(16'hC0DE ^ {11'd0, phy}));
    usr_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] l1, l2, pa2, pl2;
    rst_n = 0; enable = 0; usr_req = 0; usr_wr = 0; usr_phy = '0; usr_reg = '0;
    usr_wdata = '0; chg_clr_wr = 0; chg_clr_bits = '0; chg_mask_wr = 0; chg_mask_bits = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(alive == 0 && link == 0, "R1 alive/link reset", alive | link, 32'd0);
    chk(chg_raw == 0 && chg_masked == 0, "R1 change reset", chg_raw | chg_masked, 32'd0);
    chk(!fe_req && idle, "R1 idle, no frame", {30'd0, fe_req, idle}, 32'd1);
    repeat (10) @(negedge clk);
    chk(frames_started == 0 && idle, "R9 no frame while disabled", 32'(frames_started), 32'd0);

    // first full pass
    phy_alive = 32'hA5C3_0F69; phy_link = 32'h0FF0_33CC;
    l1 = phy_alive & phy_link;
    enable = 1;
    wait_scans(32);
    chk(alive == phy_alive, "R3 alive after pass", alive, phy_alive);
    chk(link == l1, "R4 link after pass", link, l1);
    chk(chg_raw == l1, "R5 raw after first pass", chg_raw, l1);
    chk(chg_masked == 0, "R6 masked with zero mask", chg_masked, 32'd0);

    chg_mask_wr = 1; chg_mask_bits = 32'hFFFF_0000;
    @(negedge clk); chg_mask_wr = 0;
    chk(chg_masked == (l1 & 32'hFFFF_0000), "R6 masked", chg_masked, l1 & 32'hFFFF_0000);

    chg_clr_wr = 1; chg_clr_bits = 32'h0000_FFFF;
    @(negedge clk); chg_clr_wr = 0;
    chk(chg_raw == (l1 & 32'hFFFF_0000), "R5 partial clear", chg_raw, l1 & 32'hFFFF_0000);
    chg_clr_wr = 1; chg_clr_bits = 32'hFFFF_FFFF;
    @(negedge clk); chg_clr_wr = 0;
    chk(chg_raw == 0, "R5 full clear", chg_raw, 32'd0);

    // second pass with changed PHYs
    pa2 = phy_alive ^ 32'h0101_0F0F; pl2 = phy_link ^ 32'hF000_000F;
    phy_alive = pa2; phy_link = pl2;
    l2 = pa2 & pl2;
    wait_scans(33);
    chk(alive == pa2, "R3 alive set and cleared", alive, pa2);
    chk(link == l2, "R4 link updated", link, l2);
    chk(chg_raw == (l1 ^ l2), "R5 raw after link changes", chg_raw, l1 ^ l2);
    chk(chg_masked == ((l1 ^ l2) & 32'hFFFF_0000), "R6 masked after changes",
        chg_masked, (l1 ^ l2) & 32'hFFFF_0000);

    // software access between polls
    soft_op(1'b0, 5'd7, 16'h0000);
    soft_op(1'b1, 5'd30, 16'h5A3C);
    soft_op(1'b0, 5'd0, 16'h0000);
    wait_scans(3);

    // disable in mid frame
    begin
      int n, s; bit seen;
      wait_mid_frame();
      enable = 0;
      n = frames_started; s = scan_done; seen = 0;
      for (int i = 0; i < 50 && !seen; i++) begin
        @(negedge clk);
        if (idle) seen = 1;
      end
      chk(seen, "R9 idle after disable", 32'(seen), 32'd1);
      chk(scan_done == s + 1, "R9 frame in flight completed", 32'(scan_done), 32'(s + 1));
      repeat (20) @(negedge clk);
      chk(frames_started == n && !fe_req, "R9 no new frame", 32'(frames_started), 32'(n));
    end
    enable = 1;
    wait_scans(4);
    chk(alive == pa2, "R3 alive stable after resume", alive, pa2);
    report();
  end

endmodule